// File: doc/BRIEF.md
# MDIO Station Management Controller

This block gives a host a small register view of the two-wire PHY management bus. There are two host registers. The data port holds the 16-bit value to be sent on a write. It also receives the 16-bit value the PHY returns on a read. The control word holds the PHY address and the PHY register address, plus two start bits: one for a read and one for a write.

Writing the control word with a start bit set launches a complete management frame. The frame has 32 preamble ones, the start code, the opcode, both addresses MSB first, a turnaround and 16 data bits MSB first. The block generates the management clock from the system clock with a programmable divider. The start bit stays readable as set while the frame runs and clears by itself at the end. The host polls until both start bits read zero, then reads the data port for a read result.

During a read, the block releases the data line from the turnaround onward. It samples the PHY's bits on rising edges of the management clock. A control word written while a frame is running is discarded.

Top module: `mdio_regctl`

## Requirements
- R1: After reset the control word and the data port read 0, `mdc` is low and `mdio_oe` is low.
- R2: The control word (host_addr=0) reads back the PHY address in bits [4:0] and the register address in bits [12:8]. Bits 13 and 7:5 read 0.
- R3: Bit 14 of a control write starts a read and bit 15 starts a write. If both bits are set, a write is started. If neither bit is set, only the address fields are updated and no frame is sent.
- R4: The start bit of the running operation (bit 14 for a read, bit 15 for a write) reads 1 from the edge that accepts the start. It clears exactly 128*DIV_HALF system cycles later. The other start bit reads 0.
- R5: A write frame on `mdio_o`, MSB first, is: 32 ones, 01, 01, PHY address, register address, 10, and the data port value at the moment of the start. `mdio_oe` is high for all 64 bits.
- R6: A read frame drives 32 ones, 01, 10, PHY address and register address. `mdio_oe` is low from the turnaround (bit 46 of 0..63) to the end of the frame.
- R7: On a read, `mdio_i` is sampled on the 16 rising `mdc` edges of bits 48..63, MSB first. The 16-bit result appears at the data port (host_addr=1) when busy clears.
- R8: `mdc` is low while idle. While busy, it is low for DIV_HALF cycles and then high for DIV_HALF cycles per bit. `mdio_o` changes only when `mdc` falls.
- R9: A control write while a frame is running is ignored. The address fields keep their values and no further frame follows.
- R10: Data-port writes (host_addr=1) update the data port at any time. A frame already running keeps the data it latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 1 | Register select: 0 control word, 1 data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read value of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situations to reach from the ports are host writes that arrive while a frame is in flight. These are a second start request and a data-port rewrite. Their effect shows only as the absence of change in the rest of the frame and in the next frame. The stimulus issues both kinds of write in the middle of running frames. A cycle-accurate model then checks every clock that the wire pattern, the busy bits and the address fields stay on the originally launched frame. A behavioural PHY drives chosen return patterns onto `mdio_i` during the read data bits, and the data port is read back after completion.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_POS    = FRAME_LEN - DATA_W - 2;
    localparam int DAT_POS   = FRAME_LEN - DATA_W;
    localparam int BIT_W     = $clog2(FRAME_LEN);

    typedef enum logic { OP_WRITE = 1'b0, OP_READ = 1'b1 } mdio_op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
    } mdio_target_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(
        input mdio_op_e          op,
        input mdio_target_t      tgt,
        input logic [DATA_W-1:0] wdata
    );
        logic [1:0] opc;
        logic [1:0] ta;
        logic [DATA_W-1:0] dat;
        opc = (op == OP_READ) ? 2'b10 : 2'b01;
        ta  = (op == OP_READ) ? 2'b00 : 2'b10;
        dat = (op == OP_READ) ? '0 : wdata;
        return {{PRE_LEN{1'b1}}, 2'b01, opc, tgt.phy, tgt.regad, ta, dat};
    endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_HALF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap      = run && (cnt_q == CNT_LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    mdc_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  mdio_op_e             op_in,
    input  logic [FRAME_LEN-1:0] frame_in,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 is_read,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_value
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] sh_q;
    logic [BIT_W-1:0]     bit_q;
    logic [DATA_W-1:0]    cap_q;
    logic                 last;

    assign last     = fall_tick && (bit_q == LAST_BIT);
    assign done     = busy && last;
    assign mdio_o   = sh_q[FRAME_LEN-1];
    assign mdio_oe  = busy && !(is_read && (bit_q >= BIT_W'(TA_POS)));
    assign rd_value = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            is_read <= 1'b0;
            sh_q    <= '0;
            bit_q   <= '0;
            cap_q   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                is_read <= (op_in == OP_READ);
                sh_q    <= frame_in;
                bit_q   <= '0;
            end
        end else begin
            if (rise_tick && is_read && (bit_q >= BIT_W'(DAT_POS)))
                cap_q <= {cap_q[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
                if (last) busy <= 1'b0;
            end
        end
    end

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mdio_oe) |-> is_read);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !fall_tick && !$past(fall_tick)) |=> $stable(mdio_o) || !busy);
endmodule

// File: rtl/mdio_regctl.sv
module mdio_regctl
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic        host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int RD_BIT = 14;
    localparam int WR_BIT = 15;

    mdio_target_t         tgt_q;
    mdio_target_t         tgt_new;
    logic [DATA_W-1:0]    data_q;
    logic                 busy;
    logic                 is_read;
    logic                 done;
    logic [DATA_W-1:0]    rd_value;
    logic                 rise_tick;
    logic                 fall_tick;
    logic                 ctrl_wr;
    logic                 start;
    mdio_op_e             op_sel;
    logic [FRAME_LEN-1:0] frame;
    logic [15:0]          ctrl_view;

    assign ctrl_wr       = host_we && !host_addr && !busy;
    assign start         = ctrl_wr && (host_wdata[WR_BIT] || host_wdata[RD_BIT]);
    assign op_sel        = host_wdata[WR_BIT] ? OP_WRITE : OP_READ;
    assign tgt_new.phy   = host_wdata[ADDR_W-1:0];
    assign tgt_new.regad = host_wdata[8+ADDR_W-1:8];
    assign frame         = build_frame(op_sel, tgt_new, data_q);

    always_comb begin
        ctrl_view                = '0;
        ctrl_view[ADDR_W-1:0]    = tgt_q.phy;
        ctrl_view[8+ADDR_W-1:8]  = tgt_q.regad;
        ctrl_view[RD_BIT]        = busy && is_read;
        ctrl_view[WR_BIT]        = busy && !is_read;
    end

    assign host_rdata = host_addr ? data_q : ctrl_view;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            data_q <= '0;
        end else begin
            if (ctrl_wr) tgt_q <= tgt_new;
            if (done && is_read)
                data_q <= rd_value;
            else if (host_we && host_addr)
                data_q <= host_wdata;
        end
    end

    mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk(clk), .rst(rst), .run(busy),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst(rst), .start(start), .op_in(op_sel), .frame_in(frame),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .busy(busy), .is_read(is_read), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .done(done), .rd_value(rd_value)
    );

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && host_we && !host_addr) |=> $stable(tgt_q));

    // R8
    mdc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $fell(mdc));
endmodule

// File: tb/sim_mdio_regctl.sv
`timescale 1ns/1ps
module sim_mdio_regctl;
    localparam int H = 10;
    localparam int TXN = 128 * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_addr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // reference model state
    logic [4:0]  m_phy, m_reg;
    logic [15:0] m_data;
    logic        m_busy, m_rd;
    int          m_p;
    logic [63:0] m_frame;
    logic [15:0] m_resp = 16'h0000;

    mdio_regctl #(.DIV_HALF(H)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        logic rd_done;
        cycles++;
        rd_done = 1'b0;
        if (rst) begin
            m_phy = '0; m_reg = '0; m_data = '0; m_busy = 0; m_rd = 0; m_p = 0; m_frame = '0;
        end else begin
            if (m_busy) begin
                m_p++;
                if (m_p == TXN) begin
                    m_busy = 0;
                    if (m_rd) begin m_data = m_resp; rd_done = 1'b1; end
                end
            end else if (host_we && !host_addr) begin
                m_phy = host_wdata[4:0];
                m_reg = host_wdata[12:8];
                if (host_wdata[15] || host_wdata[14]) begin
                    m_busy  = 1;
                    m_rd    = !host_wdata[15];
                    m_p     = 0;
                    m_frame = {32'hFFFF_FFFF, 2'b01, m_rd ? 2'b10 : 2'b01, m_phy, m_reg,
                               m_rd ? 2'b00 : 2'b10, m_rd ? 16'h0000 : m_data};
                end
            end
            if (host_we && host_addr && !rd_done) m_data = host_wdata;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // per-cycle comparison and PHY response
    always @(negedge clk) begin
        int k;
        logic [15:0] exp_ctrl;
        k = m_p / (2 * H);
        if (!rst) begin
            exp_ctrl = {m_busy && !m_rd, m_busy && m_rd, 1'b0, m_reg, 3'b000, m_phy};
            chk("R8 mdc", {15'h0, mdc}, {15'h0, m_busy && ((m_p / H) % 2 == 1)});
            chk("R6 mdio_oe", {15'h0, mdio_oe}, {15'h0, m_busy && !(m_rd && k >= 46)});
            if (m_busy && !(m_rd && k >= 46))
                chk(m_rd ? "R6 read frame" : "R5 write frame", {15'h0, mdio_o}, {15'h0, m_frame[63-k]});
            if (!host_addr) chk("R4 R2 control word", host_rdata, exp_ctrl);
            else            chk("R7 R10 data port", host_rdata, m_data);
        end
        mdio_i = (m_busy && m_rd && k >= 48) ? m_resp[63-k] : 1'b1;
    end

    task automatic hwrite(input logic a, input logic [15:0] d);
        @(posedge clk); #1;
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_we = 1'b0; host_addr = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(posedge clk);
        #1;
    endtask

    task automatic peek_data(input logic [15:0] exp, input string tag);
        @(posedge clk); #1; host_addr = 1'b1;
        @(negedge clk); chk(tag, host_rdata, exp);
        @(posedge clk); #1; host_addr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 ctrl reset", host_rdata, 16'h0000);
        chk("R1 mdc reset", {15'h0, mdc}, 16'h0);
        chk("R1 oe reset", {15'h0, mdio_oe}, 16'h0);
        peek_data(16'h0000, "R1 data reset");

        // R3 neither start bit: fields only, no frame
        hwrite(1'b0, 16'h2A_EB & 16'h1F1F | 16'h2000);
        repeat (5) @(negedge clk);
        chk("R3 no frame", {15'h0, mdio_oe}, 16'h0);
        chk("R2 fields", host_rdata, 16'h0A0B);

        // R5 write with R10 data change mid-frame and R9 ignored start
        hwrite(1'b1, 16'hA5C3);
        hwrite(1'b0, 16'h8000 | (16'h05 << 8) | 16'h11);
        repeat (200) @(posedge clk);
        hwrite(1'b1, 16'h1234);
        hwrite(1'b0, 16'h4000 | (16'h1E << 8) | 16'h02);
        wait_idle();
        repeat (3) @(posedge clk);
        chk("R9 no second frame", {15'h0, mdio_oe}, 16'h0);
        peek_data(16'h1234, "R10 data kept");

        // R6 R7 read
        m_resp = 16'hBEEF;
        hwrite(1'b0, 16'h4000 | (16'h1A << 8) | 16'h1F);
        wait_idle();
        peek_data(16'hBEEF, "R7 read result");

        m_resp = 16'h0001;
        hwrite(1'b0, 16'h4000);
        wait_idle();
        peek_data(16'h0001, "R7 read result 2");

        // R3 both bits: write wins
        hwrite(1'b1, 16'h8001);
        hwrite(1'b0, 16'hC000 | (16'h03 << 8) | 16'h04);
        @(negedge clk);
        chk("R3 both bits is write", host_rdata, 16'h8304);
        wait_idle();
        peek_data(16'h8001, "R3 data unchanged by write");

        repeat (10) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule